// File: doc/BRIEF.md
# Interrupt Priority and Acceptance Unit

This unit keeps the interrupt bookkeeping of one local interrupt controller: a 256-bit pending map, a 256-bit in-service map and a 256-bit trigger-kind map, plus an 8-bit task priority. From the task priority and the highest in-service vector it derives a processor priority, and it presents the highest pending vector to the core whenever that vector's priority class beats the processor priority.

Vectors arrive on an accept port with a level/edge flag. The core takes an offered vector through the inject-acknowledge strobe, which moves it from pending to in-service. An end-of-interrupt strobe retires the highest in-service vector; if that vector was level-triggered, the vector is broadcast for one cycle so the I/O interrupt router can re-arm its line. A pending vector below 16 is illegal: it is swapped for a configured error vector and an error flag is raised.

Top module: `ipa_unit`

## Requirements
- R1: After reset, offer_valid, ppr, err_status and eoi_bc_valid are all zero.
- R2: Processor priority equals the 8-bit task priority when task priority bits 7:4 are greater than or equal to the class (bits 7:4) of the highest in-service vector, and otherwise equals that class in bits 7:4 with bits 3:0 zero; ppr follows a change of its inputs one clock later.
- R3: With no vector in service the in-service class counts as 0, so ppr equals the task priority.
- R4: A pending vector is offered only when its value masked with 0xF0 is strictly greater than ppr; equal classes are held back.
- R5: Only the highest-numbered pending vector is considered for the offer.
- R6: inj_ack with inj_vector sets that vector's in-service bit and clears its pending bit in the same clock; ppr follows one clock later.
- R7: eoi_wr clears the highest in-service bit; if that vector's trigger-kind bit was set, the bit is cleared and eoi_bc_valid pulses for one cycle, in the clock after eoi_wr, with the vector on eoi_bc_vector. An EOI with nothing in service changes nothing.
- R8: A level accept (acc_level = 1) sets the pending and trigger-kind bits; a level accept of a vector already pending is discarded and leaves the trigger-kind bit clear.
- R9: A task-priority write keeps only tpr_wdata bits 7:0.
- R10: When the highest pending vector is below 16, one clock later its pending bit is cleared, err_lvt_vector becomes pending and err_status bit 5 (0x20) is set and stays set; no vector below 16 is ever offered.
- R11: While sw_en is low, accepts have no effect.
- R12: When an accept and an acknowledge of the same vector fall in one clock, the vector ends both pending and in service.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_en | input | 1 | Software enable; accepts are dropped while low |
| acc_valid | input | 1 | Accept strobe |
| acc_vector | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data (bits 7:0 used) |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| inj_ack | input | 1 | Core has injected inj_vector |
| inj_vector | input | 8 | Vector being acknowledged |
| err_lvt_vector | input | 8 | Vector raised in place of an illegal one |
| offer_valid | output | 1 | A vector is eligible for delivery |
| offer_vector | output | 8 | Highest pending vector |
| ppr | output | 8 | Processor priority |
| eoi_bc_valid | output | 1 | One-cycle pulse: level vector retired |
| eoi_bc_vector | output | 8 | Vector retired by that EOI |
| err_status | output | 8 | Error flags; bit 5 = illegal vector seen |

## Verification
The pair that can coincide is accept and acknowledge, which both write the pending map, and acknowledge with EOI, which both write the in-service map. The bench drives an accept and an acknowledge of the same vector in one clock and judges the outcome through ppr rising to that vector's class while the vector is still offered after a following EOI. It also drives a level accept onto an already pending vector and judges the discard by the absence of a broadcast when that vector is later retired.

// File: rtl/ipa_pkg.sv
// Package: ipa_pkg
// Shared constants for the interrupt priority and acceptance unit.
// Assumes a vector is one byte whose upper nibble is its priority class.
package ipa_pkg;
    localparam int VEC_COUNT     = 256;
    localparam int VEC_W         = $clog2(VEC_COUNT);
    localparam int CLASS_W       = 4;
    localparam int LOW_VEC_LIMIT = 16;
    localparam int ERR_W         = 8;
    localparam int ERR_ILLEGAL   = 5;
    localparam int TPR_BUS_W     = 32;
endpackage

// File: rtl/ipa_msb_find.sv
// Module: ipa_msb_find
// Combinational search for the highest set bit of a bitmap.
// Assumes WIDTH is a power of two; idx is zero when found is low.
module ipa_msb_find #(
    parameter int WIDTH = ipa_pkg::VEC_COUNT,
    parameter int IW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [IW-1:0]    idx,
    output logic             found
);
    // Scan upward so the last set bit seen is the highest one.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipa_ppr_calc.sv
// Module: ipa_ppr_calc
// Registers the processor priority from the task priority and the
// highest in-service vector. Assumes the class is the upper CLASS_W bits.
module ipa_ppr_calc #(
    parameter int VW = ipa_pkg::VEC_W,
    parameter int CW = ipa_pkg::CLASS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] tpr_q,
    input  logic [VW-1:0] isr_top,
    input  logic          isr_any,
    output logic [VW-1:0] ppr_q
);
    localparam int LOW_W = VW - CW;

    logic [CW-1:0] svc_cls;
    logic [VW-1:0] ppr_n;

    // Pick task priority or in-service class, whichever ranks higher.
    always_comb begin
        svc_cls = isr_any ? isr_top[VW-1:LOW_W] : '0;
        if (tpr_q[VW-1:LOW_W] >= svc_cls)
            ppr_n = tpr_q;
        else
            ppr_n = {svc_cls, {LOW_W{1'b0}}};
    end

    // Hold the priority one clock behind its inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) ppr_q <= '0;
        else        ppr_q <= ppr_n;
    end

    // R2: the priority class never falls below the task priority class.
    assert_ppr_not_below_tpr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_q[VW-1:LOW_W] >= $past(tpr_q[VW-1:LOW_W]));

    // R3: with nothing in service the task priority passes through.
    assert_ppr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(isr_any) |-> ppr_q == $past(tpr_q));
endmodule

// File: rtl/ipa_vec_maps.sv
// Module: ipa_vec_maps
// Pending, in-service and trigger-kind bitmaps with their update rules,
// the illegal-vector swap, the error flag and the EOI broadcast register.
// Assumes highest-bit results for the pending and in-service maps are
// supplied by the parent from the registered maps.
module ipa_vec_maps #(
    parameter int NV    = ipa_pkg::VEC_COUNT,
    parameter int VW    = $clog2(NV),
    parameter int LOWV  = ipa_pkg::LOW_VEC_LIMIT,
    parameter int EW    = ipa_pkg::ERR_W,
    parameter int EBIT  = ipa_pkg::ERR_ILLEGAL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_en,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_vector,
    input  logic          acc_level,
    input  logic          inj_ack,
    input  logic [VW-1:0] inj_vector,
    input  logic          eoi_wr,
    input  logic [VW-1:0] err_lvt_vector,
    input  logic [VW-1:0] irr_top,
    input  logic          irr_any,
    input  logic [VW-1:0] isr_top,
    input  logic          isr_any,
    output logic [NV-1:0] irr_q,
    output logic [NV-1:0] isr_q,
    output logic          eoi_bc_valid,
    output logic [VW-1:0] eoi_bc_vector,
    output logic [EW-1:0] err_q
);
    localparam logic [NV-1:0] ONE = NV'(1);

    logic [NV-1:0] tmr_q;
    logic          acc_take;
    logic          eoi_do;
    logic          eoi_lvl;
    logic          illegal;
    logic [NV-1:0] irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;

    // Decide which events fire this clock and build set/clear masks.
    always_comb begin
        acc_take = acc_valid && sw_en && !(acc_level && irr_q[acc_vector]);
        eoi_do   = eoi_wr && isr_any;
        eoi_lvl  = eoi_do && tmr_q[isr_top];
        illegal  = irr_any && (irr_top < VW'(LOWV));

        irr_set = '0;
        irr_clr = '0;
        isr_set = '0;
        isr_clr = '0;
        tmr_set = '0;
        tmr_clr = '0;

        if (acc_take)            irr_set |= ONE << acc_vector;
        if (acc_take && acc_level) tmr_set |= ONE << acc_vector;
        if (illegal) begin
            irr_clr |= ONE << irr_top;
            irr_set |= ONE << err_lvt_vector;
        end
        if (inj_ack) begin
            irr_clr |= ONE << inj_vector;
            isr_set |= ONE << inj_vector;
        end
        if (eoi_do)  isr_clr |= ONE << isr_top;
        if (eoi_lvl) tmr_clr |= ONE << isr_top;
    end

    // Apply clears first so a same-clock set of the same bit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= (irr_q & ~irr_clr) | irr_set;
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            tmr_q <= (tmr_q & ~tmr_clr) | tmr_set;
        end
    end

    // Register the EOI broadcast pulse and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bc_valid  <= 1'b0;
            eoi_bc_vector <= '0;
        end else begin
            eoi_bc_valid  <= eoi_lvl;
            eoi_bc_vector <= eoi_lvl ? isr_top : '0;
        end
    end

    // Latch the illegal-vector flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= '0;
        else if (illegal) err_q <= err_q | (EW'(1) << EBIT);
    end

    // R6: an acknowledged vector is in service on the next clock.
    assert_ack_sets_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_ack |=> isr_q[$past(inj_vector)]);

    // R7: a broadcast only follows an EOI strobe.
    assert_bc_needs_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> $past(eoi_wr));

    // R8: a fresh level accept marks the vector as level-triggered.
    assert_level_marks_tmr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sw_en && acc_level && !irr_q[acc_vector]) |=> tmr_q[$past(acc_vector)]);

    // R10: the illegal-vector flag is sticky.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_q[EBIT]) |-> err_q[EBIT]);

    // R11: with enable low and no other writer, a clear pending bit stays clear.
    assert_disabled_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !sw_en && !irr_q[acc_vector] && !illegal)
        |=> !irr_q[$past(acc_vector)]);
endmodule

// File: rtl/ipa_unit.sv
// Module: ipa_unit
// Top of the interrupt priority and acceptance unit: task priority register,
// highest-bit searches, processor priority and the delivery gate.
// Assumes one accept, one acknowledge and one EOI at most per clock.
module ipa_unit #(
    parameter int NUM_VEC = ipa_pkg::VEC_COUNT,
    parameter int TPR_W   = ipa_pkg::TPR_BUS_W,
    parameter int ERR_W   = ipa_pkg::ERR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sw_en,
    input  logic                       acc_valid,
    input  logic [$clog2(NUM_VEC)-1:0] acc_vector,
    input  logic                       acc_level,
    input  logic                       tpr_wr,
    input  logic [TPR_W-1:0]           tpr_wdata,
    input  logic                       eoi_wr,
    input  logic                       inj_ack,
    input  logic [$clog2(NUM_VEC)-1:0] inj_vector,
    input  logic [$clog2(NUM_VEC)-1:0] err_lvt_vector,
    output logic                       offer_valid,
    output logic [$clog2(NUM_VEC)-1:0] offer_vector,
    output logic [$clog2(NUM_VEC)-1:0] ppr,
    output logic                       eoi_bc_valid,
    output logic [$clog2(NUM_VEC)-1:0] eoi_bc_vector,
    output logic [ERR_W-1:0]           err_status
);
    localparam int VW    = $clog2(NUM_VEC);
    localparam int CW    = ipa_pkg::CLASS_W;
    localparam int LOW_W = VW - CW;

    logic [VW-1:0]      tpr_q;
    logic [NUM_VEC-1:0] irr_q, isr_q;
    logic [VW-1:0]      irr_top, isr_top;
    logic               irr_any, isr_any;

    // Store the low byte of each task-priority write.
    always_ff @(posedge clk) begin
        if (!rst_n)      tpr_q <= '0;
        else if (tpr_wr) tpr_q <= tpr_wdata[VW-1:0];
    end

    ipa_msb_find #(.WIDTH(NUM_VEC), .IW(VW)) u_irr_find (
        .bits (irr_q),
        .idx  (irr_top),
        .found(irr_any)
    );

    ipa_msb_find #(.WIDTH(NUM_VEC), .IW(VW)) u_isr_find (
        .bits (isr_q),
        .idx  (isr_top),
        .found(isr_any)
    );

    ipa_ppr_calc #(.VW(VW), .CW(CW)) u_ppr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tpr_q  (tpr_q),
        .isr_top(isr_top),
        .isr_any(isr_any),
        .ppr_q  (ppr)
    );

    ipa_vec_maps #(.NV(NUM_VEC), .VW(VW), .EW(ERR_W)) u_maps (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_en         (sw_en),
        .acc_valid     (acc_valid),
        .acc_vector    (acc_vector),
        .acc_level     (acc_level),
        .inj_ack       (inj_ack),
        .inj_vector    (inj_vector),
        .eoi_wr        (eoi_wr),
        .err_lvt_vector(err_lvt_vector),
        .irr_top       (irr_top),
        .irr_any       (irr_any),
        .isr_top       (isr_top),
        .isr_any       (isr_any),
        .irr_q         (irr_q),
        .isr_q         (isr_q),
        .eoi_bc_valid  (eoi_bc_valid),
        .eoi_bc_vector (eoi_bc_vector),
        .err_q         (err_status)
    );

    // Gate the highest pending vector on its class beating the priority.
    always_comb begin
        offer_vector = irr_top;
        offer_valid  = irr_any && ({irr_top[VW-1:LOW_W], {LOW_W{1'b0}}} > ppr);
    end

    // R9: the task priority register holds the written low byte.
    assert_tpr_low_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr |=> tpr_q == $past(tpr_wdata[VW-1:0]));

    // R10: no vector below the legal limit ever reaches the core.
    assert_offer_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> offer_vector >= VW'(ipa_pkg::LOW_VEC_LIMIT));

    // R1: nothing is offered in the first clock after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !offer_valid && !eoi_bc_valid);
endmodule

// File: tb/ipa_unit_tb.sv
`timescale 1ns/1ps
module ipa_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_en = 1'b1;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_vector = '0;
    logic        acc_level = 1'b0;
    logic        tpr_wr = 1'b0;
    logic [31:0] tpr_wdata = '0;
    logic        eoi_wr = 1'b0;
    logic        inj_ack = 1'b0;
    logic [7:0]  inj_vector = '0;
    logic [7:0]  err_lvt_vector = 8'hE3;
    logic        offer_valid;
    logic [7:0]  offer_vector;
    logic [7:0]  ppr;
    logic        eoi_bc_valid;
    logic [7:0]  eoi_bc_vector;
    logic [7:0]  err_status;

    int   n_checks = 0;
    int   n_errors = 0;
    logic done = 1'b0;
    logic bc_v;
    logic [7:0] bc_vec;

    always #2.5 clk = ~clk;

    ipa_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .eoi_wr(eoi_wr),
        .inj_ack(inj_ack), .inj_vector(inj_vector), .err_lvt_vector(err_lvt_vector),
        .offer_valid(offer_valid), .offer_vector(offer_vector), .ppr(ppr),
        .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector),
        .err_status(err_status)
    );

    // op codes: 0 edge accept, 1 level accept, 2 tpr write, 3 ack, 4 eoi
    // fields: {op[3], data[8], exp_valid, exp_vec[8], exp_ppr[8], exp_bc, exp_bcvec[8]}
    localparam int NSTEP = 13;
    localparam logic [36:0] STEPS [NSTEP] = '{
        {3'd0, 8'h35, 1'b1, 8'h35, 8'h00, 1'b0, 8'h00}, // R4 offer above ppr 0
        {3'd0, 8'h62, 1'b1, 8'h62, 8'h00, 1'b0, 8'h00}, // R5 highest pending wins
        {3'd2, 8'h60, 1'b0, 8'h00, 8'h60, 1'b0, 8'h00}, // R4 equal class held back
        {3'd2, 8'h5F, 1'b1, 8'h62, 8'h5F, 1'b0, 8'h00}, // R2/R3 ppr = tpr
        {3'd3, 8'h62, 1'b0, 8'h00, 8'h60, 1'b0, 8'h00}, // R6 ack raises ppr
        {3'd2, 8'h7A, 1'b0, 8'h00, 8'h7A, 1'b0, 8'h00}, // R2 tpr class above
        {3'd2, 8'h6C, 1'b0, 8'h00, 8'h6C, 1'b0, 8'h00}, // R2 tpr class equal
        {3'd2, 8'h00, 1'b0, 8'h00, 8'h60, 1'b0, 8'h00}, // R2 service class above
        {3'd1, 8'h91, 1'b1, 8'h91, 8'h60, 1'b0, 8'h00}, // R8 level accept
        {3'd3, 8'h91, 1'b0, 8'h00, 8'h90, 1'b0, 8'h00}, // R6 ack
        {3'd4, 8'h00, 1'b0, 8'h00, 8'h60, 1'b1, 8'h91}, // R7 level eoi broadcast
        {3'd4, 8'h00, 1'b1, 8'h35, 8'h00, 1'b0, 8'h00}, // R7 edge eoi silent
        {3'd4, 8'h00, 1'b1, 8'h35, 8'h00, 1'b0, 8'h00}  // R7 empty eoi no effect
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One stimulus clock, then one settle clock for the registered priority.
    task automatic cycle(input logic av, input logic [7:0] avec, input logic alvl,
                         input logic ack, input logic [7:0] avk, input logic eoi,
                         input logic tw, input logic [31:0] td);
        @(negedge clk);
        acc_valid = av; acc_vector = avec; acc_level = alvl;
        inj_ack = ack; inj_vector = avk; eoi_wr = eoi;
        tpr_wr = tw; tpr_wdata = td;
        @(negedge clk);
        acc_valid = 1'b0; inj_ack = 1'b0; eoi_wr = 1'b0; tpr_wr = 1'b0;
        bc_v = eoi_bc_valid; bc_vec = eoi_bc_vector;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(offer_valid == 1'b0, "R1 offer_valid", offer_valid, 0);
        check(ppr == 8'h00, "R1 ppr", ppr, 0);
        check(err_status == 8'h00, "R1 err_status", err_status, 0);
        check(eoi_bc_valid == 1'b0, "R1 eoi_bc_valid", eoi_bc_valid, 0);

        for (int i = 0; i < NSTEP; i++) begin
            logic [36:0] s;
            s = STEPS[i];
            case (s[36:34])
                3'd0: cycle(1, s[33:26], 0, 0, 0, 0, 0, 0);
                3'd1: cycle(1, s[33:26], 1, 0, 0, 0, 0, 0);
                3'd2: cycle(0, 0, 0, 0, 0, 0, 1, {24'hFFFF00, s[33:26]});
                3'd3: cycle(0, 0, 0, 1, s[33:26], 0, 0, 0);
                default: cycle(0, 0, 0, 0, 0, 1, 0, 0);
            endcase
            check(offer_valid == s[25], $sformatf("table row %0d offer_valid", i),
                  offer_valid, s[25]);
            if (s[25])
                check(offer_vector == s[24:17], $sformatf("table row %0d offer_vector", i),
                      offer_vector, s[24:17]);
            check(ppr == s[16:9], $sformatf("table row %0d ppr", i), ppr, s[16:9]);
            check(bc_v == s[8], $sformatf("table row %0d eoi_bc_valid", i), bc_v, s[8]);
            if (s[8])
                check(bc_vec == s[7:0], $sformatf("table row %0d eoi_bc_vector", i),
                      bc_vec, s[7:0]);
        end

        // R9 upper write bits dropped
        cycle(0, 0, 0, 0, 0, 0, 1, 32'hABCD_1240);
        check(ppr == 8'h40, "R9 tpr low byte", ppr, 8'h40);
        check(offer_valid == 1'b0, "R9 gate with tpr 0x40", offer_valid, 0);
        cycle(0, 0, 0, 0, 0, 0, 1, 32'h0);

        // R11 accept while disabled
        sw_en = 1'b0;
        cycle(1, 8'hC0, 0, 0, 0, 0, 0, 0);
        check(offer_vector == 8'h35, "R11 disabled accept", offer_vector, 8'h35);
        sw_en = 1'b1;

        // R8 level duplicate of a pending edge vector is discarded
        cycle(1, 8'hA0, 0, 0, 0, 0, 0, 0);
        check(offer_vector == 8'hA0, "R8 edge accept", offer_vector, 8'hA0);
        cycle(1, 8'hA0, 1, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 1, 8'hA0, 0, 0, 0);
        check(ppr == 8'hA0, "R6 ppr after ack", ppr, 8'hA0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0);
        check(bc_v == 1'b0, "R8 duplicate left no level mark", bc_v, 0);
        check(offer_vector == 8'h35, "R7 eoi retired A0", offer_vector, 8'h35);

        // R12 accept and acknowledge of one vector in the same clock
        cycle(1, 8'hB0, 0, 0, 0, 0, 0, 0);
        cycle(1, 8'hB0, 0, 1, 8'hB0, 0, 0, 0);
        check(ppr == 8'hB0, "R12 in service", ppr, 8'hB0);
        check(offer_valid == 1'b0, "R12 held by ppr", offer_valid, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0);
        check(offer_valid && offer_vector == 8'hB0, "R12 still pending",
              offer_vector, 8'hB0);
        cycle(0, 0, 0, 1, 8'hB0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0);

        // R10 illegal low vector swapped for the error vector
        cycle(0, 0, 0, 1, 8'h35, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 0, 0);
        check(offer_valid == 1'b0, "R10 map empty", offer_valid, 0);
        check(err_status == 8'h00, "R10 no error yet", err_status, 0);
        cycle(1, 8'h05, 0, 0, 0, 0, 0, 0);
        check(err_status == 8'h20, "R10 err bit 5", err_status, 8'h20);
        check(offer_valid && offer_vector == 8'hE3, "R10 error vector offered",
              offer_vector, 8'hE3);
        cycle(0, 0, 0, 0, 0, 0, 0, 0);
        check(err_status == 8'h20, "R10 err sticky", err_status, 8'h20);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule